// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block is the per-processor presentation stage of a two-level interrupt controller. A source stage offers interrupts to it, each as a source number with an 8-bit priority. Numerically smaller priorities are more favored. The block keeps one 32-bit pending word. Bits 31:24 hold the processor's current priority and bits 23:0 hold the number of the source now presented. A source number of zero means nothing is presented. Alongside the word it keeps the priority of the presented source and the priority of a pending inter-processor interrupt (IPI).

An offer competes with the current priority and with whatever is already presented. The loser is bounced back to the source stage as a reject, and the source stage must offer it again after a resend request. The processor drives a one-clock command port with four operations: set current priority, set IPI priority, accept and end-of-interrupt. The block drives a single interrupt line to the processor. The IPI occupies the reserved source number 2. It never reaches the source stage as a reject.

All outputs are registered, so the effect of a command or offer shows up one clock later. When a command and an offer arrive in the same clock, the command is applied first. The offer is then judged against the state the command leaves. Each of the two stages has its own reject lane.

Top module: `irq_present_unit`

## Requirements
- R1: After reset the pending word is 0 (current priority 0x00, source 0), the line is low, no pulse is active, and the IPI priority is 0xFF, which means no IPI.
- R2: An offer at priority P is rejected when P >= current priority, or when a source is presented whose priority is <= P. The reject appears on the offer lane (offRejPulse, offRejSrc = offered source) one clock later, and the pending word is unchanged.
- R3: An offer that wins latches its source and priority and raises the line. Any source it displaces is rejected on the offer lane.
- R4: Command ACCEPT (cmdOp=2) returns the pending word on rdData with rdValid one clock later. It lowers the line and reloads the word with current priority = presented priority and source = 0.
- R5: Command SET_CPPR (cmdOp=0, cmdData[7:0]) with a value below the current priority stores it. If a source is presented whose priority is >= the new value, the source field clears, the line drops and that source is rejected on the command lane.
- R6: SET_CPPR with a value equal to or above the current priority stores it. If nothing is presented, it starts a resend: resendPulse for one clock, preceded by the IPI check when the IPI priority is below the new current priority.
- R7: Command SET_IPI (cmdOp=1, cmdData[7:0]) stores the IPI priority and runs the IPI check only when the value is below the current priority. A winning check rejects the presented source on the command lane, latches source 2 with the IPI priority and raises the line.
- R8: The IPI check changes nothing when a source is presented whose priority is <= the IPI priority.
- R9: Command EOI (cmdOp=3) loads the current priority from cmdData[31:24] and pulses eoiPulse with eoiSrc = cmdData[23:0]. If nothing is presented it then starts a resend, as in R6.
- R10: A reject whose source is the IPI number 2 is dropped on both lanes, and no pulse appears.
- R11: With a command and an offer in the same clock, the offer is judged against the state after the command. Both lanes may pulse in that clock.
- R12: The interrupt line is high exactly when the source field of the pending word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| offerValid | input | 1 | Offer from the source stage this clock |
| offerSrc | input | 24 | Offered source number |
| offerPrio | input | 8 | Offered priority |
| cmdValid | input | 1 | Command this clock |
| cmdOp | input | 2 | 0 set current priority, 1 set IPI priority, 2 accept, 3 end-of-interrupt |
| cmdData | input | 32 | Command operand |
| rdData | output | 32 | Pending word returned by accept |
| rdValid | output | 1 | rdData valid pulse |
| pendingWord | output | 32 | Current priority (31:24) and presented source (23:0) |
| cpuIrq | output | 1 | Interrupt line to the processor |
| offRejPulse | output | 1 | Reject from offer arbitration |
| offRejSrc | output | 24 | Source rejected by offer arbitration |
| cmdRejPulse | output | 1 | Reject caused by a command |
| cmdRejSrc | output | 24 | Source rejected by a command |
| eoiPulse | output | 1 | End-of-interrupt to the source stage |
| eoiSrc | output | 24 | Source being retired |
| resendPulse | output | 1 | Resend request to the source stage |

## Verification
A command and an offer can land in the same clock, and the offer must then be judged against the post-command state. The bench provokes this twice. In the first case, raising the current priority from 0x00 to 0x80 lets an offer at 0x10 win, where the old priority would have bounced it. In the second case, lowering the current priority clears a presented source on the command lane while the simultaneous offer loses on the offer lane. In each case the bench judges the pending word, the line and both reject lanes in the following clock.

// File: rtl/irq_present_pkg.sv
package irq_present_pkg;
  localparam int PRIO_W = 8;
  localparam int SRC_W  = 24;
  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  typedef enum logic [1:0] {
    OP_SET_CPPR = 2'd0,
    OP_SET_IPI  = 2'd1,
    OP_ACCEPT   = 2'd2,
    OP_EOI      = 2'd3
  } presentOp_t;

  // next-state values and pulse strobes from control to datapath
  typedef struct packed {
    logic [PRIO_W-1:0] cppr;
    logic [SRC_W-1:0]  src;
    logic [PRIO_W-1:0] pend;
    logic [PRIO_W-1:0] ipi;
    logic              line;
    logic              rdLoad;
    logic              offRej;
    logic [SRC_W-1:0]  offRejSrc;
    logic              cmdRej;
    logic [SRC_W-1:0]  cmdRejSrc;
    logic              eoi;
    logic [SRC_W-1:0]  eoiSrc;
    logic              resend;
  } presentStrobe_t;
endpackage

// File: rtl/irq_present_ctrl.sv
module irq_present_ctrl
  import irq_present_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SOURCE = 24'd2
) (
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [WORD_W-1:0] cmdData,
  input  logic              offerValid,
  input  logic [SRC_W-1:0]  offerSrc,
  input  logic [PRIO_W-1:0] offerPrio,
  input  logic [PRIO_W-1:0] curCppr,
  input  logic [SRC_W-1:0]  curSrc,
  input  logic [PRIO_W-1:0] curPend,
  input  logic [PRIO_W-1:0] curIpi,
  input  logic              curLine,
  output presentStrobe_t    strobe
);
  logic [PRIO_W-1:0] c, p, m, newPrio;
  logic [SRC_W-1:0]  x;
  logic              l, doResend, doCheck;
  logic              cmdRejRaw, offRejRaw;
  logic [SRC_W-1:0]  cmdRejRawSrc, offRejRawSrc;

  always_comb begin
    c = curCppr; x = curSrc; p = curPend; m = curIpi; l = curLine;
    newPrio = cmdData[PRIO_W-1:0];
    doResend = 1'b0; doCheck = 1'b0;
    cmdRejRaw = 1'b0; cmdRejRawSrc = '0;
    offRejRaw = 1'b0; offRejRawSrc = '0;
    strobe = '0;

    // command stage
    if (cmdValid) begin
      unique case (presentOp_t'(cmdOp))
        OP_SET_CPPR: begin
          if (newPrio < c) begin
            if ((x != '0) && (newPrio <= p)) begin
              cmdRejRaw = 1'b1; cmdRejRawSrc = x;
              x = '0; l = 1'b0;
            end
            c = newPrio;
          end else begin
            c = newPrio;
            if (x == '0) doResend = 1'b1;
          end
        end
        OP_SET_IPI: begin
          m = newPrio;
          if (m < c) doCheck = 1'b1;
        end
        OP_ACCEPT: begin
          strobe.rdLoad = 1'b1;
          c = p; x = '0; l = 1'b0;
        end
        OP_EOI: begin
          c = cmdData[WORD_W-1:SRC_W];
          strobe.eoi = 1'b1;
          strobe.eoiSrc = cmdData[SRC_W-1:0];
          if (x == '0) doResend = 1'b1;
        end
        default: ;
      endcase
    end

    if (doResend) begin
      strobe.resend = 1'b1;
      if (m < c) doCheck = 1'b1;
    end

    if (doCheck && !((x != '0) && (p <= m))) begin
      if (x != '0) begin
        cmdRejRaw = 1'b1; cmdRejRawSrc = x;
      end
      x = IPI_SOURCE; p = m; l = 1'b1;
    end

    // offer stage, judged against the post-command state
    if (offerValid) begin
      if ((offerPrio >= c) || ((x != '0) && (p <= offerPrio))) begin
        offRejRaw = 1'b1; offRejRawSrc = offerSrc;
      end else begin
        if (x != '0) begin
          offRejRaw = 1'b1; offRejRawSrc = x;
        end
        x = offerSrc; p = offerPrio; l = 1'b1;
      end
    end

    // the IPI never travels back to the source stage
    strobe.cmdRej    = cmdRejRaw && (cmdRejRawSrc != IPI_SOURCE);
    strobe.cmdRejSrc = cmdRejRawSrc;
    strobe.offRej    = offRejRaw && (offRejRawSrc != IPI_SOURCE);
    strobe.offRejSrc = offRejRawSrc;

    strobe.cppr = c; strobe.src = x; strobe.pend = p;
    strobe.ipi = m; strobe.line = l;
  end
endmodule

// File: rtl/irq_present_dp.sv
module irq_present_dp
  import irq_present_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  presentStrobe_t    strobe,
  output logic [PRIO_W-1:0] curCppr,
  output logic [SRC_W-1:0]  curSrc,
  output logic [PRIO_W-1:0] curPend,
  output logic [PRIO_W-1:0] curIpi,
  output logic              curLine,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              offRejPulse,
  output logic [SRC_W-1:0]  offRejSrc,
  output logic              cmdRejPulse,
  output logic [SRC_W-1:0]  cmdRejSrc,
  output logic              eoiPulse,
  output logic [SRC_W-1:0]  eoiSrc,
  output logic              resendPulse
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCppr <= '0;
      curSrc <= '0;
      curPend <= '0;
      curIpi <= PRIO_NONE;
      curLine <= 1'b0;
      rdData <= '0;
      rdValid <= 1'b0;
      offRejPulse <= 1'b0;
      offRejSrc <= '0;
      cmdRejPulse <= 1'b0;
      cmdRejSrc <= '0;
      eoiPulse <= 1'b0;
      eoiSrc <= '0;
      resendPulse <= 1'b0;
    end else begin
      if (strobe.rdLoad) rdData <= {curCppr, curSrc};
      rdValid <= strobe.rdLoad;
      curCppr <= strobe.cppr;
      curSrc <= strobe.src;
      curPend <= strobe.pend;
      curIpi <= strobe.ipi;
      curLine <= strobe.line;
      offRejPulse <= strobe.offRej;
      offRejSrc <= strobe.offRejSrc;
      cmdRejPulse <= strobe.cmdRej;
      cmdRejSrc <= strobe.cmdRejSrc;
      eoiPulse <= strobe.eoi;
      eoiSrc <= strobe.eoiSrc;
      resendPulse <= strobe.resend;
    end
  end
endmodule

// File: rtl/irq_present_unit.sv
module irq_present_unit
  import irq_present_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SOURCE = 24'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              offerValid,
  input  logic [SRC_W-1:0]  offerSrc,
  input  logic [PRIO_W-1:0] offerPrio,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [WORD_W-1:0] cmdData,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic [WORD_W-1:0] pendingWord,
  output logic              cpuIrq,
  output logic              offRejPulse,
  output logic [SRC_W-1:0]  offRejSrc,
  output logic              cmdRejPulse,
  output logic [SRC_W-1:0]  cmdRejSrc,
  output logic              eoiPulse,
  output logic [SRC_W-1:0]  eoiSrc,
  output logic              resendPulse
);
  presentStrobe_t    strobe;
  logic [PRIO_W-1:0] curCppr, curPend, curIpi;
  logic [SRC_W-1:0]  curSrc;
  logic              curLine;

  irq_present_ctrl #(.IPI_SOURCE(IPI_SOURCE)) ctrl (
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .offerValid(offerValid), .offerSrc(offerSrc), .offerPrio(offerPrio),
    .curCppr(curCppr), .curSrc(curSrc), .curPend(curPend),
    .curIpi(curIpi), .curLine(curLine), .strobe(strobe)
  );

  irq_present_dp dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .curCppr(curCppr), .curSrc(curSrc), .curPend(curPend),
    .curIpi(curIpi), .curLine(curLine),
    .rdData(rdData), .rdValid(rdValid),
    .offRejPulse(offRejPulse), .offRejSrc(offRejSrc),
    .cmdRejPulse(cmdRejPulse), .cmdRejSrc(cmdRejSrc),
    .eoiPulse(eoiPulse), .eoiSrc(eoiSrc), .resendPulse(resendPulse)
  );

  assign pendingWord = {curCppr, curSrc};
  assign cpuIrq = curLine;
endmodule

// File: rtl/irq_present_chk.sv
module irq_present_chk
  import irq_present_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SOURCE = 24'd2
) (
  input logic              clk,
  input logic              rstN,
  input logic              offerValid,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic [WORD_W-1:0] cmdData,
  input logic [WORD_W-1:0] rdData,
  input logic              rdValid,
  input logic [WORD_W-1:0] pendingWord,
  input logic              cpuIrq,
  input logic              offRejPulse,
  input logic [SRC_W-1:0]  offRejSrc,
  input logic              cmdRejPulse,
  input logic [SRC_W-1:0]  cmdRejSrc,
  input logic              eoiPulse,
  input logic [SRC_W-1:0]  eoiSrc
);
  logic armed;
  always_ff @(posedge clk) armed <= rstN;

  assert_line_tracks_src_R12: assert property (@(posedge clk) disable iff (!rstN || !armed)
    cpuIrq == (pendingWord[SRC_W-1:0] != '0));

  assert_accept_returns_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_ACCEPT) |=> (rdValid && rdData == $past(pendingWord)));

  assert_accept_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_ACCEPT && !offerValid) |=> (!cpuIrq && pendingWord[SRC_W-1:0] == '0));

  assert_eoi_forward_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_EOI) |=> (eoiPulse && eoiSrc == $past(cmdData[SRC_W-1:0])));

  assert_eoi_cppr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_EOI) |=> (pendingWord[WORD_W-1:SRC_W] == $past(cmdData[WORD_W-1:SRC_W])));

  assert_no_ipi_offer_reject_R10: assert property (@(posedge clk) disable iff (!rstN)
    offRejPulse |-> (offRejSrc != IPI_SOURCE));

  assert_no_ipi_cmd_reject_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdRejPulse |-> (cmdRejSrc != IPI_SOURCE));

  assert_idle_no_pulses_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid && !offerValid) |=> (!offRejPulse && !cmdRejPulse && !eoiPulse && $stable(pendingWord)));
endmodule

bind irq_present_unit irq_present_chk #(.IPI_SOURCE(IPI_SOURCE)) chk (
  .clk(clk), .rstN(rstN), .offerValid(offerValid), .cmdValid(cmdValid),
  .cmdOp(cmdOp), .cmdData(cmdData), .rdData(rdData), .rdValid(rdValid),
  .pendingWord(pendingWord), .cpuIrq(cpuIrq),
  .offRejPulse(offRejPulse), .offRejSrc(offRejSrc),
  .cmdRejPulse(cmdRejPulse), .cmdRejSrc(cmdRejSrc),
  .eoiPulse(eoiPulse), .eoiSrc(eoiSrc)
);

// File: tb/irq_present_unit_test.sv
module irq_present_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic offerValid = 1'b0;
  logic [23:0] offerSrc = '0;
  logic [7:0] offerPrio = '0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [31:0] cmdData = '0;
  logic [31:0] rdData, pendingWord;
  logic rdValid, cpuIrq, offRejPulse, cmdRejPulse, eoiPulse, resendPulse;
  logic [23:0] offRejSrc, cmdRejSrc, eoiSrc;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk; // 50 MHz

  irq_present_unit uut (
    .clk(clk), .rstN(rstN), .offerValid(offerValid), .offerSrc(offerSrc),
    .offerPrio(offerPrio), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .rdData(rdData), .rdValid(rdValid), .pendingWord(pendingWord), .cpuIrq(cpuIrq),
    .offRejPulse(offRejPulse), .offRejSrc(offRejSrc),
    .cmdRejPulse(cmdRejPulse), .cmdRejSrc(cmdRejSrc),
    .eoiPulse(eoiPulse), .eoiSrc(eoiSrc), .resendPulse(resendPulse)
  );

  typedef struct packed {
    logic [7:0] tag;
    logic       cv;
    logic [1:0] op;
    logic [7:0] d;
    logic [7:0] ds;
    logic       ov;
    logic [7:0] os;
    logic [7:0] opr;
    logic [7:0] ewc;
    logic [7:0] ews;
    logic       el;
    logic       eor;
    logic [7:0] eors;
    logic       ecr;
    logic [7:0] ecrs;
    logic       ee;
    logic       eres;
  } vec_t;

  function automatic vec_t v(input logic [7:0] tag, input logic cv, input logic [1:0] op,
                             input logic [7:0] d, input logic [7:0] ds, input logic ov,
                             input logic [7:0] os, input logic [7:0] opr,
                             input logic [7:0] ewc, input logic [7:0] ews, input logic el,
                             input logic eor, input logic [7:0] eors,
                             input logic ecr, input logic [7:0] ecrs,
                             input logic ee, input logic eres);
    return '{tag, cv, op, d, ds, ov, os, opr, ewc, ews, el, eor, eors, ecr, ecrs, ee, eres};
  endfunction

  // tag: requirement number. op 0 set cppr, 1 set ipi, 2 accept, 3 eoi
  localparam int NVEC = 17;
  localparam vec_t VEC [NVEC] = '{
    v(6,  1,0,8'hFF,0,    0,0,0,       8'hFF,8'h00,0, 0,0,       0,0,       0,1), // R6 resend, ipi FF idle
    v(3,  0,0,0,0,        1,8'h20,5,   8'hFF,8'h20,1, 0,0,       0,0,       0,0), // R3 latch
    v(2,  0,0,0,0,        1,8'h21,5,   8'hFF,8'h20,1, 1,8'h21,   0,0,       0,0), // R2 tie loses
    v(3,  0,0,0,0,        1,8'h22,3,   8'hFF,8'h22,1, 1,8'h20,   0,0,       0,0), // R3 displace
    v(8,  1,1,8'h04,0,    0,0,0,       8'hFF,8'h22,1, 0,0,       0,0,       0,0), // R8 check no-op
    v(7,  1,1,8'h01,0,    0,0,0,       8'hFF,8'h02,1, 0,0,       1,8'h22,   0,0), // R7 ipi wins
    v(10, 0,0,0,0,        1,8'h23,0,   8'hFF,8'h23,1, 0,0,       0,0,       0,0), // R10 ipi displaced silently
    v(4,  1,2,0,0,        0,0,0,       8'h00,8'h00,0, 0,0,       0,0,       0,0), // R4 accept
    v(2,  0,0,0,0,        1,8'h24,2,   8'h00,8'h00,0, 1,8'h24,   0,0,       0,0), // R2 vs cppr
    v(9,  1,3,8'hFF,8'h23,0,0,0,       8'hFF,8'h02,1, 0,0,       0,0,       1,1), // R9 eoi + resend + ipi
    v(5,  1,0,8'h01,0,    0,0,0,       8'h01,8'h00,0, 0,0,       0,0,       0,0), // R5 clear ipi, R10 no pulse
    v(7,  1,1,8'hFF,0,    0,0,0,       8'h01,8'h00,0, 0,0,       0,0,       0,0), // R7 no check
    v(3,  0,0,0,0,        1,8'h25,0,   8'h01,8'h25,1, 0,0,       0,0,       0,0), // R3
    v(5,  1,0,8'h00,0,    0,0,0,       8'h00,8'h00,0, 0,0,       1,8'h25,   0,0), // R5 clear + reject
    v(11, 1,0,8'h80,0,    1,8'h26,8'h10, 8'h80,8'h26,1, 0,0,     0,0,       0,1), // R11 offer after cmd
    v(11, 1,0,8'h08,0,    1,8'h27,8'h09, 8'h08,8'h00,0, 1,8'h27, 1,8'h26,   0,0), // R11 both lanes
    v(6,  1,0,8'h08,0,    0,0,0,       8'h08,8'h00,0, 0,0,       0,0,       0,1)  // R6 equal
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    chk(req, {31'd0, offRejPulse}, 0);
    chk(req, {31'd0, cmdRejPulse}, 0);
    chk(req, {31'd0, eoiPulse}, 0);
    chk(req, {31'd0, resendPulse}, 0);
    chk(req, {31'd0, rdValid}, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    string tagName;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 word", pendingWord, 32'h0);
    chk("R1 line", {31'd0, cpuIrq}, 0);
    checkIdle("R1");
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", pendingWord, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t e;
      e = VEC[i];
      tagName = $sformatf("R%0d step %0d", e.tag, i);
      cmdValid = e.cv; cmdOp = e.op;
      cmdData = (e.op == 2'd3) ? {e.d, 16'h0, e.ds} : {24'h0, e.d};
      offerValid = e.ov; offerSrc = {16'h0, e.os}; offerPrio = e.opr;
      @(negedge clk);
      cmdValid = 1'b0; offerValid = 1'b0;
      chk({tagName, " word"}, pendingWord, {e.ewc, 16'h0, e.ews});
      chk({tagName, " line"}, {31'd0, cpuIrq}, {31'd0, e.el});
      chk({tagName, " offRej"}, {31'd0, offRejPulse}, {31'd0, e.eor});
      if (e.eor) chk({tagName, " offRejSrc"}, {8'h0, offRejSrc}, {24'h0, e.eors});
      chk({tagName, " cmdRej"}, {31'd0, cmdRejPulse}, {31'd0, e.ecr});
      if (e.ecr) chk({tagName, " cmdRejSrc"}, {8'h0, cmdRejSrc}, {24'h0, e.ecrs});
      chk({tagName, " eoi"}, {31'd0, eoiPulse}, {31'd0, e.ee});
      if (e.ee) chk({tagName, " eoiSrc"}, {8'h0, eoiSrc}, {24'h0, e.ds});
      chk({tagName, " resend"}, {31'd0, resendPulse}, {31'd0, e.eres});
    end

    // R4 accept read-back: present 0x30 at prio 2 under cppr 0x08
    offerValid = 1'b1; offerSrc = 24'h30; offerPrio = 8'h02;
    @(negedge clk);
    offerValid = 1'b0;
    chk("R3 latch 0x30", pendingWord, 32'h08000030);
    cmdValid = 1'b1; cmdOp = 2'd2;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R4 rdValid", {31'd0, rdValid}, 1);
    chk("R4 rdData", rdData, 32'h08000030);
    chk("R4 reload", pendingWord, 32'h02000000);
    chk("R12 line low", {31'd0, cpuIrq}, 0);
    @(negedge clk);
    checkIdle("R4 pulses single");

    // R1 reset mid-run restores IPI priority 0xFF: after reset, raising cppr must not latch an IPI
    cmdValid = 1'b1; cmdOp = 2'd1; cmdData = 32'h0;
    @(negedge clk);
    cmdValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset word", pendingWord, 32'h0);
    cmdValid = 1'b1; cmdOp = 2'd0; cmdData = 32'hFF;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R1 no ipi after reset", pendingWord, 32'hFF000000);
    chk("R6 resend", {31'd0, resendPulse}, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule